// File: doc/BRIEF.md
# Precision-Controlled Rounding Unit

This unit takes an unpacked floating-point result and coerces it to one of three destination precisions: extended, double or single. The result arrives as a sign, a signed 32-bit exponent, a normalized 64-bit significand with an explicit leading one, and a 16-bit word of guard and sticky bits below the significand. The unit denormalizes results that are too small for the chosen precision, rounds them under one of four rounding directions, and replaces results that are too large with either infinity or the largest finite value of that precision.

The unit is a three-stage pipeline: denormalize, round, overflow check. A valid bit travels with each operand, and one new operand can enter every cycle. Alongside the coerced value it reports four flags: underflow, overflow, inexact, and a flag that marks a significand incremented by rounding. The result stays in the unpacked layout, with the significand kept left-aligned. Any bit below the precision's last kept bit comes out as zero.

Top module: `prec_round_unit`

## Requirements
- R1: Reset clears `out_valid` and every flag. An operand presented with `in_valid` high appears on the outputs, with `out_valid` high, exactly three clock cycles later, and `out_valid` stays low in the cycles in between.
- R2: Each precision has a minimum exponent: 0 for extended, 0x3F81 for single and 0x3C01 for double. When the input exponent (signed) is below it, the exponent becomes that minimum and the 80-bit concatenation {significand, guard word} is shifted right by the difference. Underflow is raised unless rule R4 clears it.
- R3: The denormalizing shift is sticky: any nonzero bit shifted out sets bit 0 of the guard word. Shift distances larger than 66 behave as a shift of 66, so the shift stays correct for any exponent down to 0x80000000.
- R4: If no nonzero bit lies below the precision's LSB (guard and sticky all zero), the result is exact. The value is unchanged, and underflow, inexact and increment are all low. Otherwise inexact is raised.
- R5: In round-to-nearest (mode code 00), with the 16-bit rounding word G formed from the bits below the LSB and the remaining bits ORed into its bit 0, the significand is incremented when G > 0x8000, or when G = 0x8000 and the LSB is 1.
- R6: Mode 01 (toward +infinity) increments an inexact result only when the sign is 0. Mode 10 (toward −infinity) increments only when the sign is 1. Mode 11 (toward zero) never increments.
- R7: An increment adds one unit at the LSB and raises `out_inc`. A carry out of bit 63 leaves the significand 0x8000000000000000 and adds one to the exponent.
- R8: Precision code 00 is extended (LSB at significand bit 0), 01 is double (LSB at bit 11), 10 is single (LSB at bit 40), and 11 is treated as extended. Significand bits below the LSB are moved into G and come out as zero.
- R9: The maximum exponent is 0x7FFE for extended, 0x407E for single and 0x43FE for double. An exponent above it after rounding raises overflow and inexact. An exponent equal to it does not overflow.
- R10: On overflow, the result is infinity (exponent 0x7FFF, significand zero) in mode 00, in mode 01 with sign 0, and in mode 10 with sign 1. In all other cases it is the largest finite value: the maximum exponent with 64 ones (extended), 53 leading ones (double) or 24 leading ones (single).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | 32 | Biased exponent, two's complement |
| in_sig | input | 64 | Normalized significand, explicit leading bit |
| in_grd | input | 16 | Guard and sticky bits below the significand |
| in_prec | input | 2 | Destination precision: 00 extended, 01 double, 10 single, 11 extended |
| in_rmode | input | 2 | Rounding mode: 00 nearest, 01 up, 10 down, 11 toward zero |
| out_valid | output | 1 | Result present this cycle |
| out_sign | output | 1 | Result sign |
| out_exp | output | 32 | Result exponent |
| out_sig | output | 64 | Result significand |
| out_uf | output | 1 | Underflow |
| out_of | output | 1 | Overflow |
| out_ix | output | 1 | Inexact |
| out_inc | output | 1 | Significand was incremented by rounding |

## Verification
Each pipeline stage holds its state only between two clock edges. A wrong internal value therefore reaches the ports within three cycles, on the same `out_valid` beat as the operand that caused it. A bad denormalizing shift shows as a wrong exponent or a wrong LSB, or as lost stickiness that turns a round-up into a truncation. A wrong rounding word shows as a flipped `out_inc` or as a significand off by one unit at the precision's LSB. Errors in thresholds or in the choice between infinity and the largest finite value show directly in `out_exp`, `out_sig` and `out_of` for operands placed just at or just beyond each limit.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    localparam int SIG_W     = 64;
    localparam int GRD_W     = 16;
    localparam int EXP_W     = 32;
    localparam int VEC_W     = SIG_W + GRD_W;
    localparam int SHIFT_CAP = 66;
    localparam int CNT_W     = $clog2(SHIFT_CAP + 1);
    localparam int PIPE_LAT  = 3;

    localparam logic [EXP_W-1:0] INF_EXP  = 32'h0000_7FFF;
    localparam logic [GRD_W-1:0] HALF_ULP = 16'h8000;

    typedef enum logic [1:0] {
        PR_EXT = 2'b00,
        PR_DBL = 2'b01,
        PR_SGL = 2'b10,
        PR_XTA = 2'b11
    } prec_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_UP   = 2'b01,
        RM_DOWN = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    // operand entering the pipe and leaving the denormalize stage
    typedef struct packed {
        logic             valid;
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
        logic [GRD_W-1:0] grd;
        prec_e            prec;
        rmode_e           rm;
    } op_t;

    typedef struct packed {
        op_t  op;
        logic uf;
    } dn_t;

    typedef struct packed {
        logic             valid;
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
        prec_e            prec;
        rmode_e           rm;
        logic             uf;
        logic             ix;
        logic             inc;
    } rd_t;

    typedef struct packed {
        logic             valid;
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
        logic             uf;
        logic             of;
        logic             ix;
        logic             inc;
    } res_t;

    function automatic logic [EXP_W-1:0] min_exp(prec_e p);
        case (p)
            PR_SGL:  return 32'h0000_3F81;
            PR_DBL:  return 32'h0000_3C01;
            default: return '0;
        endcase
    endfunction

    function automatic logic [EXP_W-1:0] max_exp(prec_e p);
        case (p)
            PR_SGL:  return 32'h0000_407E;
            PR_DBL:  return 32'h0000_43FE;
            default: return 32'h0000_7FFE;
        endcase
    endfunction

    function automatic int lsb_idx(prec_e p);
        case (p)
            PR_SGL:  return 40;
            PR_DBL:  return 11;
            default: return 0;
        endcase
    endfunction

    // ones from the top down to the LSB of the precision
    function automatic logic [SIG_W-1:0] keep_mask(prec_e p);
        return {SIG_W{1'b1}} << lsb_idx(p);
    endfunction

    function automatic logic overflow_to_inf(rmode_e rm, logic sign);
        case (rm)
            RM_NEAR: return 1'b1;
            RM_UP:   return ~sign;
            RM_DOWN: return sign;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rnd_denorm.sv
module rnd_denorm
    import rnd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_t  op_i,
    output dn_t  dn_o
);
    localparam logic signed [EXP_W+1:0] CAP_S = (EXP_W+2)'(SHIFT_CAP);

    logic signed [EXP_W+1:0] gap;
    logic [CNT_W-1:0]        cnt;
    logic [VEC_W-1:0]        vec, shifted, lost_mask;
    logic                    tiny;
    dn_t                     nxt;

    always_comb begin
        gap  = $signed({2'b00, min_exp(op_i.prec)})
             - $signed({{2{op_i.exp[EXP_W-1]}}, op_i.exp});
        tiny = gap > 0;
        if (!tiny)
            cnt = '0;
        else if (gap > CAP_S)
            cnt = CNT_W'(SHIFT_CAP);
        else
            cnt = gap[CNT_W-1:0];

        vec       = {op_i.sig, op_i.grd};
        shifted   = vec >> cnt;
        lost_mask = ~({VEC_W{1'b1}} << cnt);

        nxt        = '0;
        nxt.op     = op_i;
        nxt.uf     = tiny;
        if (tiny) begin
            nxt.op.exp = min_exp(op_i.prec);
            nxt.op.sig = shifted[VEC_W-1:GRD_W];
            nxt.op.grd = {shifted[GRD_W-1:1],
                          shifted[0] | (|(vec & lost_mask))};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dn_o <= '0;
        else     dn_o <= nxt;
    end
endmodule

// File: rtl/rnd_round.sv
module rnd_round
    import rnd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dn_t  dn_i,
    output rd_t  rd_o
);
    int                 lsb;
    logic [VEC_W-1:0]   below;
    logic [GRD_W-1:0]   gw;
    logic [SIG_W-1:0]   kept;
    logic [SIG_W:0]     sum;
    logic               exact, bump, lsb_bit;
    rd_t                nxt;

    always_comb begin
        lsb     = lsb_idx(dn_i.op.prec);
        below   = {dn_i.op.sig, dn_i.op.grd} << (SIG_W - lsb);
        gw      = {below[VEC_W-1:SIG_W+1],
                   below[SIG_W] | (|below[SIG_W-1:0])};
        kept    = dn_i.op.sig & keep_mask(dn_i.op.prec);
        lsb_bit = dn_i.op.sig[lsb];
        exact   = (gw == '0);

        bump = 1'b0;
        if (!exact) begin
            case (dn_i.op.rm)
                RM_NEAR: bump = (gw > HALF_ULP) || (gw == HALF_ULP && lsb_bit);
                RM_UP:   bump = ~dn_i.op.sign;
                RM_DOWN: bump = dn_i.op.sign;
                default: bump = 1'b0;
            endcase
        end

        sum = {1'b0, kept} + ((SIG_W+1)'(1) << lsb);

        nxt       = '0;
        nxt.valid = dn_i.op.valid;
        nxt.sign  = dn_i.op.sign;
        nxt.exp   = dn_i.op.exp;
        nxt.sig   = kept;
        nxt.prec  = dn_i.op.prec;
        nxt.rm    = dn_i.op.rm;
        nxt.uf    = dn_i.uf & ~exact;
        nxt.ix    = ~exact;
        nxt.inc   = bump;
        if (bump) begin
            if (sum[SIG_W]) begin
                nxt.sig = {1'b1, sum[SIG_W-1:1]};
                nxt.exp = dn_i.op.exp + 1'b1;
            end else begin
                nxt.sig = sum[SIG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_o <= '0;
        else     rd_o <= nxt;
    end
endmodule

// File: rtl/rnd_ovf.sv
module rnd_ovf
    import rnd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rd_t  rd_i,
    output res_t res_o
);
    logic huge;
    res_t nxt;

    always_comb begin
        huge      = $signed(rd_i.exp) > $signed(max_exp(rd_i.prec));
        nxt.valid = rd_i.valid;
        nxt.sign  = rd_i.sign;
        nxt.exp   = rd_i.exp;
        nxt.sig   = rd_i.sig;
        nxt.uf    = rd_i.uf;
        nxt.of    = huge;
        nxt.ix    = rd_i.ix | huge;
        nxt.inc   = rd_i.inc;
        if (huge) begin
            if (overflow_to_inf(rd_i.rm, rd_i.sign)) begin
                nxt.exp = INF_EXP;
                nxt.sig = '0;
            end else begin
                nxt.exp = max_exp(rd_i.prec);
                nxt.sig = keep_mask(rd_i.prec);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_o <= '0;
        else     res_o <= nxt;
    end
endmodule

// File: rtl/prec_round_unit.sv
module prec_round_unit
    import rnd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sign,
    input  logic [EXP_W-1:0] in_exp,
    input  logic [SIG_W-1:0] in_sig,
    input  logic [GRD_W-1:0] in_grd,
    input  logic [1:0]       in_prec,
    input  logic [1:0]       in_rmode,
    output logic             out_valid,
    output logic             out_sign,
    output logic [EXP_W-1:0] out_exp,
    output logic [SIG_W-1:0] out_sig,
    output logic             out_uf,
    output logic             out_of,
    output logic             out_ix,
    output logic             out_inc
);
    op_t  op_in;
    dn_t  s1;
    rd_t  s2;
    res_t s3;

    always_comb begin
        op_in.valid = in_valid;
        op_in.sign  = in_sign;
        op_in.exp   = in_exp;
        op_in.sig   = in_sig;
        op_in.grd   = in_grd;
        op_in.prec  = prec_e'(in_prec);
        op_in.rm    = rmode_e'(in_rmode);
    end

    rnd_denorm u_dn  (.clk(clk), .rst(rst), .op_i(op_in), .dn_o(s1));
    rnd_round  u_rd  (.clk(clk), .rst(rst), .dn_i(s1),    .rd_o(s2));
    rnd_ovf    u_ov  (.clk(clk), .rst(rst), .rd_i(s2),    .res_o(s3));

    assign out_valid = s3.valid;
    assign out_sign  = s3.sign;
    assign out_exp   = s3.exp;
    assign out_sig   = s3.sig;
    assign out_uf    = s3.uf;
    assign out_of    = s3.of;
    assign out_ix    = s3.ix;
    assign out_inc   = s3.inc;
endmodule

// File: rtl/prec_round_chk.sv
module prec_round_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  in_rmode,
    input logic        out_valid,
    input logic [31:0] out_exp,
    input logic [63:0] out_sig,
    input logic        out_uf,
    input logic        out_of,
    input logic        out_ix,
    input logic        out_inc
);
    p_lat_on_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

    p_lat_off_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid);

    p_exact_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ix) |-> (!out_uf && !out_of && !out_inc));

    p_chop_no_inc_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_rmode == 2'b11) |-> ##3 !out_inc);

    p_of_inexact_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_of) |-> out_ix);

    p_inf_shape_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_exp == 32'h0000_7FFF) |-> (out_of && out_sig == '0));
endmodule

bind prec_round_unit prec_round_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_rmode(in_rmode),
    .out_valid(out_valid), .out_exp(out_exp), .out_sig(out_sig),
    .out_uf(out_uf), .out_of(out_of), .out_ix(out_ix), .out_inc(out_inc)
);

// File: tb/prec_round_unit_bench.sv
module prec_round_unit_bench;
    localparam logic [1:0] P_EXT = 2'b00, P_DBL = 2'b01, P_SGL = 2'b10, P_XTA = 2'b11;
    localparam logic [1:0] M_NR = 2'b00, M_UP = 2'b01, M_DN = 2'b10, M_TZ = 2'b11;
    // flag order {uf, of, ix, inc}
    localparam logic [3:0] F_NONE = 4'b0000, F_X = 4'b0010, F_XI = 4'b0011,
                           F_UX = 4'b1010, F_UXI = 4'b1011, F_OX = 4'b0110, F_OXI = 4'b0111;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] TOP1 = 64'h8000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sign = 1'b0;
    logic [31:0] in_exp = '0;
    logic [63:0] in_sig = '0;
    logic [15:0] in_grd = '0;
    logic [1:0]  in_prec = '0, in_rmode = '0;
    logic        out_valid, out_sign, out_uf, out_of, out_ix, out_inc;
    logic [31:0] out_exp;
    logic [63:0] out_sig;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    prec_round_unit u_prec_round_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .in_grd(in_grd), .in_prec(in_prec),
        .in_rmode(in_rmode), .out_valid(out_valid), .out_sign(out_sign),
        .out_exp(out_exp), .out_sig(out_sig), .out_uf(out_uf), .out_of(out_of),
        .out_ix(out_ix), .out_inc(out_inc)
    );

    task automatic run_case(input string tag, input logic sg, input logic [31:0] ex,
                            input logic [63:0] sv, input logic [15:0] gr,
                            input logic [1:0] pr, input logic [1:0] rm,
                            input logic [31:0] e_exp, input logic [63:0] e_sig,
                            input logic [3:0] e_fl);
        logic gap_ok;
        @(negedge clk);
        in_valid = 1'b1; in_sign = sg; in_exp = ex; in_sig = sv;
        in_grd = gr; in_prec = pr; in_rmode = rm;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        gap_ok = !out_valid;   // R1: nothing after two edges
        @(negedge clk);
        total++;
        if (!(gap_ok && out_valid && out_sign == sg && out_exp == e_exp &&
              out_sig == e_sig && {out_uf, out_of, out_ix, out_inc} == e_fl)) begin
            bad++;
            $display("FAIL %s: got gap=%0b v=%0b s=%0b exp=%h sig=%h fl=%b, want gap=1 v=1 s=%0b exp=%h sig=%h fl=%b",
                     tag, gap_ok, out_valid, out_sign, out_exp, out_sig,
                     {out_uf, out_of, out_ix, out_inc}, sg, e_exp, e_sig, e_fl);
        end
    endtask

    task automatic t_reset();
        total++;
        if (out_valid !== 1'b0 || {out_uf, out_of, out_ix, out_inc} !== 4'b0) begin
            bad++;
            $display("FAIL R1 reset: got v=%b fl=%b, want v=0 fl=0000",
                     out_valid, {out_uf, out_of, out_ix, out_inc});
        end
    endtask

    task automatic t_exact();
        run_case("R4 ext exact", 0, 32'h3FFF, TOP1 | 64'h1, 16'h0, P_EXT, M_NR, 32'h3FFF, TOP1 | 64'h1, F_NONE);
        run_case("R4 sgl exact", 1, 32'h3FFF, 64'hFFFFFF00_00000000, 16'h0, P_SGL, M_UP, 32'h3FFF, 64'hFFFFFF00_00000000, F_NONE);
    endtask

    task automatic t_nearest();
        run_case("R5 tie even", 0, 32'h3FFF, TOP1 | 64'h2, 16'h8000, P_EXT, M_NR, 32'h3FFF, TOP1 | 64'h2, F_X);
        run_case("R5 tie odd",  0, 32'h3FFF, TOP1 | 64'h1, 16'h8000, P_EXT, M_NR, 32'h3FFF, TOP1 | 64'h2, F_XI);
        run_case("R5 above half", 1, 32'h3FFF, TOP1 | 64'h2, 16'h8001, P_EXT, M_NR, 32'h3FFF, TOP1 | 64'h3, F_XI);
        run_case("R5 below half", 0, 32'h3FFF, TOP1 | 64'h1, 16'h7FFF, P_EXT, M_NR, 32'h3FFF, TOP1 | 64'h1, F_X);
    endtask

    task automatic t_directed();
        run_case("R6 up pos",   0, 32'h3FFF, TOP1 | 64'h4, 16'h0001, P_EXT, M_UP, 32'h3FFF, TOP1 | 64'h5, F_XI);
        run_case("R6 up neg",   1, 32'h3FFF, TOP1 | 64'h4, 16'h0001, P_EXT, M_UP, 32'h3FFF, TOP1 | 64'h4, F_X);
        run_case("R6 down neg", 1, 32'h3FFF, TOP1 | 64'h4, 16'h0001, P_EXT, M_DN, 32'h3FFF, TOP1 | 64'h5, F_XI);
        run_case("R6 down pos", 0, 32'h3FFF, TOP1 | 64'h4, 16'h0001, P_EXT, M_DN, 32'h3FFF, TOP1 | 64'h4, F_X);
        run_case("R6 chop",     0, 32'h3FFF, TOP1 | 64'h4, 16'hFFFF, P_EXT, M_TZ, 32'h3FFF, TOP1 | 64'h4, F_X);
    endtask

    task automatic t_carry();
        run_case("R7 carry ext", 0, 32'h3FFF, ONES, 16'hFFFF, P_EXT, M_NR, 32'h4000, TOP1, F_XI);
    endtask

    task automatic t_precision();
        run_case("R8 sgl tie even", 0, 32'h3FFF, 64'h80000080_00000000, 16'h0, P_SGL, M_NR, 32'h3FFF, TOP1, F_X);
        run_case("R8 sgl tie odd",  0, 32'h3FFF, 64'h80000180_00000000, 16'h0, P_SGL, M_NR, 32'h3FFF, 64'h80000200_00000000, F_XI);
        run_case("R8 sgl grd sticky", 0, 32'h3FFF, TOP1, 16'h0001, P_SGL, M_UP, 32'h3FFF, 64'h80000100_00000000, F_XI);
        run_case("R8 dbl tie even", 0, 32'h3FFF, 64'h80000000_00000400, 16'h0, P_DBL, M_NR, 32'h3FFF, TOP1, F_X);
        run_case("R8 dbl above",    0, 32'h3FFF, 64'h80000000_00000400, 16'h0001, P_DBL, M_NR, 32'h3FFF, 64'h80000000_00000800, F_XI);
        run_case("R8 code 11 ext",  0, 32'h3FFF, TOP1 | 64'h1, 16'h8000, P_XTA, M_NR, 32'h3FFF, TOP1 | 64'h2, F_XI);
    endtask

    task automatic t_underflow();
        run_case("R2 ext exact denorm", 0, 32'hFFFF_FFFE, TOP1, 16'h0, P_EXT, M_NR, 32'h0, 64'h20000000_00000000, F_NONE);
        run_case("R2 ext tie denorm",   0, 32'hFFFF_FFFF, TOP1 | 64'h1, 16'h0, P_EXT, M_NR, 32'h0, 64'h40000000_00000000, F_UX);
        run_case("R2 ext round denorm", 1, 32'hFFFF_FFFF, TOP1 | 64'h3, 16'h0, P_EXT, M_NR, 32'h0, 64'h40000000_00000002, F_UXI);
        run_case("R2 sgl exact denorm", 0, 32'h3F80, TOP1, 16'h0, P_SGL, M_NR, 32'h3F81, 64'h40000000_00000000, F_NONE);
        run_case("R2 sgl round denorm", 0, 32'h3F69, 64'hC0000000_00000000, 16'h0, P_SGL, M_NR, 32'h3F81, 64'h00000100_00000000, F_UXI);
        run_case("R2 dbl exact denorm", 0, 32'h3C00, TOP1, 16'h0, P_DBL, M_NR, 32'h3C01, 64'h40000000_00000000, F_NONE);
    endtask

    task automatic t_sticky();
        run_case("R3 sticky at 64",  0, 32'hFFFF_FFC0, TOP1 | 64'h1, 16'h0, P_EXT, M_NR, 32'h0, 64'h1, F_UXI);
        run_case("R3 plain tie 64",  0, 32'hFFFF_FFC0, TOP1, 16'h0, P_EXT, M_NR, 32'h0, 64'h0, F_UX);
        run_case("R3 huge up",       0, 32'h8000_0000, TOP1, 16'h0, P_EXT, M_UP, 32'h0, 64'h1, F_UXI);
        run_case("R3 huge down",     0, 32'h8000_0000, TOP1, 16'h0, P_EXT, M_DN, 32'h0, 64'h0, F_UX);
    endtask

    task automatic t_overflow();
        run_case("R10 ext near inf",  0, 32'h8000, TOP1, 16'h0, P_EXT, M_NR, 32'h7FFF, 64'h0, F_OX);
        run_case("R10 ext chop max",  0, 32'h8000, TOP1, 16'h0, P_EXT, M_TZ, 32'h7FFE, ONES, F_OX);
        run_case("R10 ext up neg",    1, 32'h8000, TOP1, 16'h0, P_EXT, M_UP, 32'h7FFE, ONES, F_OX);
        run_case("R10 ext up pos",    0, 32'h8000, TOP1, 16'h0, P_EXT, M_UP, 32'h7FFF, 64'h0, F_OX);
        run_case("R10 ext down neg",  1, 32'h8000, TOP1, 16'h0, P_EXT, M_DN, 32'h7FFF, 64'h0, F_OX);
        run_case("R10 sgl chop max",  0, 32'h407F, TOP1, 16'h0, P_SGL, M_TZ, 32'h407E, 64'hFFFFFF00_00000000, F_OX);
        run_case("R10 dbl down pos",  0, 32'h43FF, TOP1, 16'h0, P_DBL, M_DN, 32'h43FE, 64'hFFFFFFFF_FFFFF800, F_OX);
        run_case("R10 dbl near neg",  1, 32'h43FF, TOP1, 16'h0, P_DBL, M_NR, 32'h7FFF, 64'h0, F_OX);
        run_case("R9 sgl at limit",   0, 32'h407E, TOP1, 16'h0, P_SGL, M_NR, 32'h407E, TOP1, F_NONE);
        run_case("R9 dbl at limit",   0, 32'h43FE, TOP1, 16'h0, P_DBL, M_NR, 32'h43FE, TOP1, F_NONE);
        run_case("R9 R7 carry to inf", 0, 32'h407E, 64'hFFFFFF80_00000000, 16'h0, P_SGL, M_NR, 32'h7FFF, 64'h0, F_OXI);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #200_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no completion, want completion before timeout");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_exact();
        t_nearest();
        t_directed();
        t_carry();
        t_precision();
        t_underflow();
        t_sticky();
        t_overflow();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule